// File: doc/BRIEF.md
# Successive Approximation Converter Sequencer

This block is the digital half of a successive approximation analog-to-digital converter. A one-cycle start pulse opens a conversion. The block first raises a sample request for one cycle so that the external track-and-hold can capture the input. It then walks a binary search over a parameterised code width. In each step it drives a trial code to an external DAC, reads a single comparator bit, and decides one result bit, starting at the most significant bit.

When the least significant bit has been decided, the full code is loaded into the result register and a done pulse is raised for one cycle. While the search runs, each decided bit is also sent out serially, most significant first, together with a valid strobe. A receiver can therefore take the code bit by bit without waiting for the parallel result.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A start pulse seen while idle raises sample_req in the next cycle for exactly one cycle. No bit is decided in that cycle (bit_valid low).
- R2: In the cycle after sample_req, dac_code holds the first trial: only bit W-1 set, every other bit 0.
- R3: The bit under trial is cleared when cmp_hi is 1 (DAC above input) and kept when cmp_hi is 0. The trial in the next cycle then has that decision in place, the next lower bit set to 1, and all bits below it 0.
- R4: Exactly W trial cycles follow the sample cycle. done is high for one cycle, W+1 cycles after the cycle in which sample_req rose.
- R5: In the done cycle, result holds the decided code. Against an ideal comparator this is the input level rounded down to a code step. For example, W=8, a 1 V reference and a 0.6 V input give 8'b10011001 (0.59765625 V).
- R6: One cycle after each trial, bit_valid is high and ser_bit carries the bit just decided. Bits come out most significant first, W strobes per conversion, and the last strobe coincides with done.
- R7: A start pulse that arrives while a conversion is in progress has no effect. It does not restart the search, does not change the code, and does not raise sample_req.
- R8: A synchronous reset returns the block to idle. In the next cycle sample_req, done and bit_valid are low, and dac_code and result are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion start pulse |
| sample_req | output | 1 | One-cycle request to sample the analog input |
| dac_code | output | W | Trial code for the external DAC |
| cmp_hi | input | 1 | Comparator: 1 when the DAC output is above the input |
| result | output | W | Final converted code |
| done | output | 1 | One-cycle pulse when result updates |
| ser_bit | output | 1 | Serial decided bit, most significant first |
| bit_valid | output | 1 | Strobe marking a valid ser_bit |

## Verification
A wrong step index or a wrong trial register shows up at dac_code one cycle after the bad decision. Because the bench predicts every trial code from the target code, such a fault is reported within a single trial. A sequencer that leaves the search too early or too late moves done and the last serial strobe away from cycle W+1 after sample_req. A restart caused by a stray start shows up as a second sample_req or a missing done. An inverted comparator decision is reported by the scoreboard at the first serial bit, well before the parallel result arrives.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_TRIAL  = 2'd2
  } sar_phase_e;

  // Apply one comparator decision to a trial code and arm the next bit.
  function automatic logic [63:0] apply_decision(
    input logic [63:0] code,
    input int unsigned pos,
    input logic        dac_above
  );
    logic [63:0] t;
    t = code;
    t[pos] = ~dac_above;
    if (pos != 0) t[pos-1] = 1'b1;
    return t;
  endfunction
endpackage

// File: rtl/sar_fsm.sv
module sar_fsm
  import sar_pkg::*;
#(
  parameter int W    = 8,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic            in_sample,
  output logic            in_trial,
  output logic            idle,
  output logic [IDXW-1:0] step,
  output logic            step_last
);
  sar_phase_e phase_q;
  logic [IDXW-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE:   if (start) phase_q <= PH_SAMPLE;
        PH_SAMPLE: begin
          phase_q <= PH_TRIAL;
          step_q  <= IDXW'(W-1);
        end
        PH_TRIAL: begin
          if (step_q == '0) phase_q <= PH_IDLE;
          else              step_q  <= step_q - 1'b1;
        end
        default:   phase_q <= PH_IDLE;
      endcase
    end
  end

  assign in_sample = (phase_q == PH_SAMPLE);
  assign in_trial  = (phase_q == PH_TRIAL);
  assign idle      = (phase_q == PH_IDLE);
  assign step      = step_q;
  assign step_last = in_trial && (step_q == '0);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
  import sar_pkg::*;
#(
  parameter int W    = 8,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_msb,
  input  logic            in_trial,
  input  logic [IDXW-1:0] step,
  input  logic            step_last,
  input  logic            cmp_hi,
  output logic [W-1:0]    trial,
  output logic [W-1:0]    result,
  output logic            done,
  output logic            ser_bit,
  output logic            bit_valid
);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]  trial_q, result_q, next_trial;
  logic [63:0]   wide_next;
  logic          done_q, ser_q, valid_q;

  always_comb begin
    wide_next  = apply_decision(64'(trial_q), int'(step), cmp_hi);
    next_trial = wide_next[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trial_q  <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
      ser_q    <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      if (load_msb) begin
        trial_q <= MSB_ONLY;
      end else if (in_trial) begin
        valid_q <= 1'b1;
        ser_q   <= ~cmp_hi;
        if (step_last) begin
          result_q <= next_trial;
          done_q   <= 1'b1;
          trial_q  <= '0;
        end else begin
          trial_q <= next_trial;
        end
      end
    end
  end

  assign trial     = trial_q;
  assign result    = result_q;
  assign done      = done_q;
  assign ser_bit   = ser_q;
  assign bit_valid = valid_q;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output logic         sample_req,
  output logic [W-1:0] dac_code,
  input  logic         cmp_hi,
  output logic [W-1:0] result,
  output logic         done,
  output logic         ser_bit,
  output logic         bit_valid
);
  localparam int IDXW = (W > 1) ? $clog2(W) : 1;

  // Named internal events for the checker
  logic            ev_idle;
  logic            ev_trial;
  logic            ev_sample;
  logic            ev_last;
  logic [IDXW-1:0] step;

  sar_fsm #(.W(W), .IDXW(IDXW)) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .in_sample (ev_sample),
    .in_trial  (ev_trial),
    .idle      (ev_idle),
    .step      (step),
    .step_last (ev_last)
  );

  sar_trial_reg #(.W(W), .IDXW(IDXW)) treg_i (
    .clk       (clk),
    .rst       (rst),
    .load_msb  (ev_sample),
    .in_trial  (ev_trial),
    .step      (step),
    .step_last (ev_last),
    .cmp_hi    (cmp_hi),
    .trial     (dac_code),
    .result    (result),
    .done      (done),
    .ser_bit   (ser_bit),
    .bit_valid (bit_valid)
  );

  assign sample_req = ev_sample;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         sample_req,
  input logic [W-1:0] dac_code,
  input logic         cmp_hi,
  input logic [W-1:0] result,
  input logic         done,
  input logic         ser_bit,
  input logic         bit_valid,
  input logic         ev_idle,
  input logic         ev_trial
);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  a_r1_start_samples: assert property (@(posedge clk) disable iff (rst)
    (ev_idle && start) |=> (sample_req && !bit_valid));

  a_r1_sample_single: assert property (@(posedge clk) disable iff (rst)
    sample_req |=> !sample_req);

  a_r2_first_trial: assert property (@(posedge clk) disable iff (rst)
    sample_req |=> (dac_code == MSB_ONLY));

  a_r3_decision_sense: assert property (@(posedge clk) disable iff (rst)
    ev_trial |=> (bit_valid && (ser_bit == !$past(cmp_hi))));

  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_last_strobe: assert property (@(posedge clk) disable iff (rst)
    done |-> bit_valid);

  a_r5_lsb_matches: assert property (@(posedge clk) disable iff (rst)
    done |-> (result[0] == ser_bit));

  a_r7_busy_start: assert property (@(posedge clk) disable iff (rst)
    (!ev_idle && start) |=> !sample_req);

  a_r8_reset_idle: assert property (@(posedge clk)
    rst |=> (!sample_req && !done && !bit_valid && dac_code == '0 && result == '0));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.W(W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .sample_req (sample_req),
  .dac_code   (dac_code),
  .cmp_hi     (cmp_hi),
  .result     (result),
  .done       (done),
  .ser_bit    (ser_bit),
  .bit_valid  (bit_valid),
  .ev_idle    (ev_idle),
  .ev_trial   (ev_trial)
);

// File: tb/sar_adc_ctrl_tb_top.sv
module sar_adc_ctrl_tb_top;
  localparam int W        = 8;
  localparam int CLK_HALF = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         sample_req;
  logic [W-1:0] dac_code;
  logic         cmp_hi;
  logic [W-1:0] result;
  logic         done;
  logic         ser_bit;
  logic         bit_valid;

  int vin_fx = 0;    // analog input in 1/16 code steps
  int n_cmp = 0;
  int n_bad = 0;
  bit mon_off = 1'b0;
  bit finished = 1'b0;

  logic [W-1:0] code_q[$];
  logic         bit_q[$];

  always #CLK_HALF clk = ~clk;

  // Ideal comparator: DAC above input
  assign cmp_hi = (int'(dac_code) * 16) > vin_fx;

  sar_adc_ctrl #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .sample_req(sample_req),
    .dac_code(dac_code), .cmp_hi(cmp_hi), .result(result), .done(done),
    .ser_bit(ser_bit), .bit_valid(bit_valid)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Monitor: pops expected serial bits and codes
  always @(negedge clk) begin
    if (!mon_off && !rst) begin
      if (bit_valid) begin
        if (bit_q.size() == 0) check("R6 unexpected strobe", 1, 0);
        else check("R6 serial bit", ser_bit, bit_q.pop_front());
      end
      if (done) begin
        if (code_q.size() == 0) check("R5 unexpected done", 1, 0);
        else check("R5 result", result, code_q.pop_front());
      end
    end
  end

  // Driver: one conversion with cycle-accurate trial checks
  task automatic run_conv(input logic [W-1:0] code, input int frac, input bit poke);
    logic [W-1:0] exp_trial;
    vin_fx = int'(code) * 16 + frac;
    code_q.push_back(code);
    for (int b = W-1; b >= 0; b--) bit_q.push_back(code[b]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 sample_req", sample_req, 1);
    check("R1 no strobe in sample", bit_valid, 0);
    @(negedge clk);
    check("R2 first trial", dac_code, {1'b1, {(W-1){1'b0}}});
    for (int j = W-1; j >= 0; j--) begin
      exp_trial = ((code >> (j+1)) << (j+1)) | (W'(1) << j);
      check("R3 trial code", dac_code, exp_trial);
      check("R4 no early done", done, 0);
      check("R7 no resample", sample_req, 0);
      start = poke && (j == W-3);
      @(negedge clk);
    end
    start = 1'b0;
    check("R4 done after W trials", done, 1);
    check("R6 last strobe with done", bit_valid, 1);
    @(negedge clk);
    check("R4 done single cycle", done, 0);
    check("R7 no restart", sample_req, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R8 reset sample_req", sample_req, 0);
    check("R8 reset done", done, 0);
    check("R8 reset strobe", bit_valid, 0);
    check("R8 reset dac_code", dac_code, 0);
    check("R8 reset result", result, 0);
    @(negedge clk);

    // 0.6 V on a 1 V reference: 0.6*256*16 = 2457.6 -> 153*16+9
    run_conv(8'b10011001, 9, 1'b0);
    check("R5 0.6V example", result, 8'b10011001);

    run_conv('0, 0, 1'b0);
    run_conv('1, 15, 1'b0);
    run_conv(8'h80, 0, 1'b0);
    run_conv(8'h7F, 15, 1'b0);
    run_conv(8'h55, 3, 1'b1);   // R7 start poked mid-conversion

    for (int i = 0; i < 24; i++)
      run_conv(W'($urandom_range(0, (1 << W) - 1)), int'($urandom_range(0, 15)), i[0]);

    // R8 reset in the middle of a conversion
    mon_off = 1'b1;
    vin_fx = 100 * 16;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R8 mid reset sample_req", sample_req, 0);
    check("R8 mid reset strobe", bit_valid, 0);
    check("R8 mid reset done", done, 0);
    check("R8 mid reset dac_code", dac_code, 0);
    check("R8 mid reset result", result, 0);
    repeat (W + 2) @(negedge clk);
    check("R8 stays idle", sample_req | done | bit_valid, 0);
    mon_off = 1'b0;

    run_conv(8'hA3, 7, 1'b0);
    repeat (2) @(negedge clk);
    check("R6 queues drained", bit_q.size() + code_q.size(), 0);
    finish_run();
  end
endmodule